// File: doc/BRIEF.md
# Byte ALU with Decimal Arithmetic

This block is the arithmetic-logic stage of an 8-bit register-to-register processor core. Each cycle it receives a destination operand, a source operand, a carry input and an operation code, and it returns the 8-bit result, the carry, sign (N) and zero (Z) flags for that result, and the full 16-bit product of the two operands. The datapath is combinational. A small status register captures the three flags whenever the core marks the operation as issued.

The operation set covers binary add and subtract (with and without carry), compare, single-step packed-decimal add and subtract with carry, the bitwise operations, invert, increment, decrement, clear, half swap, four rotates, test and multiply. The subtract family treats carry as an inverted borrow, so carry set after a subtract means no borrow was needed. Operand fetch, decode and instruction timing are left to the surrounding core.

Top module: `bcd_alu8`

## Requirements
- R1: Op code 0 (ADD) gives res = dst + src modulo 256, and op code 1 (ADC) gives res = dst + src + cin modulo 256. In both cases c_out is bit 8 of the full sum.
- R2: Op code 2 (SUB) gives res = dst - src, and op code 3 (SBB) gives res = dst - src - 1 + cin, both modulo 256. c_out is 1 exactly when the true difference is not negative, meaning no borrow.
- R3: Op code 4 (CMP) sets c_out, n_out and z_out as SUB would for dst - src. The difference is discarded, and res presents dst unchanged.
- R4: Op code 5 (DAC) treats dst and src as two-digit packed BCD, with the high digit in bits 7:4. It gives res as the BCD encoding of (dst + src + cin) mod 100, and c_out = 1 when that decimal sum is 100 or more.
- R5: Op code 6 (DSB) gives res as the BCD encoding of (dst - src - 1 + cin) mod 100, with c_out = 1 when the decimal difference is not negative.
- R6: Op codes 7 (AND), 8 (OR), 9 (XOR), 10 (INV, res = ~dst) and 13 (CLR, res = 0) always drive c_out to 0.
- R7: Op code 11 (INC) gives dst + 1, with c_out = 1 only for dst = 0xFF. Op code 12 (DEC) gives dst - 1, with c_out = 0 only for dst = 0x00.
- R8: Op code 15 (RL) rotates dst left, so bit 7 goes to both bit 0 and c_out. Op code 17 (RR) rotates right, so bit 0 goes to both bit 7 and c_out.
- R9: Op code 16 (RLC) shifts dst left with cin entering bit 0 and bit 7 going to c_out. Op code 18 (RRC) shifts right with cin entering bit 7 and bit 0 going to c_out.
- R10: Op code 14 (SWAP) exchanges bits 7:4 with bits 3:0 of dst. Op code 19 (TST) passes dst to res. Both drive c_out to 0.
- R11: Op code 20 (MPY) gives res = low byte of dst*src and c_out = 0. n_out and z_out come from the high byte of the product. prod equals dst*src for every op code.
- R12: For every op code from 0 to 19 other than CMP, n_out equals bit 7 of res and z_out is 1 exactly when res is 0.
- R13: After reset, flag_c, flag_n and flag_z are all 0. On a rising clock edge with op_en = 1 and a defined op code, they load c_out, n_out and z_out. With op_en = 0, they keep their values.
- R14: Op codes 21 to 31 give res = 0 and c_out = n_out = z_out = 0. They leave the flag register unchanged even when op_en = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the status register |
| rst | input | 1 | Synchronous active-high reset |
| op_en | input | 1 | Operation issued this cycle; the flags load on the next edge |
| op | input | 5 | Operation code |
| dst | input | 8 | Destination operand |
| src | input | 8 | Source operand |
| cin | input | 1 | Carry input |
| res | output | 8 | Operation result |
| c_out | output | 1 | Carry for this operation |
| n_out | output | 1 | Sign for this operation |
| z_out | output | 1 | Zero for this operation |
| prod | output | 16 | Product dst*src |
| flag_c | output | 1 | Registered carry |
| flag_n | output | 1 | Registered sign |
| flag_z | output | 1 | Registered zero |

## Verification
The hardest cases to reach are the decimal corner cases. One is a low digit that overflows only because of the incoming carry, as in 9 + 0 + 1. Another is a borrow that ripples through both digits, as in 00 - 00 - 1, which must wrap to 99 with carry clear. The bench reaches both by sweeping every pair of valid BCD operands with both carry values. It compares each result against a model that converts the operands to decimal integers. The binary operations are swept over every destination value against a spread of source values. The registered flags get a separate sequence, which includes a multiply whose low byte is zero but whose high byte is not.

// File: rtl/bcd_alu8_pkg.sv
package bcd_alu8_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBB  = 5'd3,
        OP_CMP  = 5'd4,
        OP_DAC  = 5'd5,
        OP_DSB  = 5'd6,
        OP_AND  = 5'd7,
        OP_OR   = 5'd8,
        OP_XOR  = 5'd9,
        OP_INV  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_CLR  = 5'd13,
        OP_SWAP = 5'd14,
        OP_RL   = 5'd15,
        OP_RLC  = 5'd16,
        OP_RR   = 5'd17,
        OP_RRC  = 5'd18,
        OP_TST  = 5'd19,
        OP_MPY  = 5'd20
    } alu_op_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ARITH,
        SEL_BCD,
        SEL_BITS,
        SEL_MUL
    } unit_sel_e;

    typedef struct packed {
        logic c;
        logic n;
        logic z;
    } alu_flags_t;

    function automatic unit_sel_e pick_unit(alu_op_e o);
        unit_sel_e s;
        case (o)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP, OP_INC, OP_DEC: s = SEL_ARITH;
            OP_DAC, OP_DSB:                                         s = SEL_BCD;
            OP_AND, OP_OR, OP_XOR, OP_INV, OP_CLR, OP_SWAP,
            OP_RL, OP_RLC, OP_RR, OP_RRC, OP_TST:                   s = SEL_BITS;
            OP_MPY:                                                 s = SEL_MUL;
            default:                                                s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic forces_c_low(alu_op_e o);
        return (o == OP_AND) || (o == OP_OR) || (o == OP_XOR) || (o == OP_INV) ||
               (o == OP_CLR) || (o == OP_SWAP) || (o == OP_TST) || (o == OP_MPY);
    endfunction

endpackage

// File: rtl/bcd_alu8_arith.sv
module bcd_alu8_arith
    import bcd_alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e          op,
    input  logic [DW-1:0]    a_dst,
    input  logic [DW-1:0]    a_src,
    input  logic             cin,
    output logic [DW-1:0]    sum,
    output logic             cout
);
    localparam logic [DW:0] ONE = {{DW{1'b0}}, 1'b1};

    logic [DW:0] ext_d, ext_s, ext_ns, ext_c, t;

    assign ext_d  = {1'b0, a_dst};
    assign ext_s  = {1'b0, a_src};
    assign ext_ns = {1'b0, ~a_src};
    assign ext_c  = {{DW{1'b0}}, cin};

    // Subtraction adds the inverted source; bit DW then reads as "no borrow".
    always_comb begin
        case (op)
            OP_ADD:         t = ext_d + ext_s;
            OP_ADC:         t = ext_d + ext_s + ext_c;
            OP_SUB, OP_CMP: t = ext_d + ext_ns + ONE;
            OP_SBB:         t = ext_d + ext_ns + ext_c;
            OP_INC:         t = ext_d + ONE;
            OP_DEC:         t = ext_d + {1'b0, {DW{1'b1}}};
            default:        t = '0;
        endcase
    end

    assign sum  = t[DW-1:0];
    assign cout = t[DW];
endmodule

// File: rtl/bcd_alu8_bcd.sv
module bcd_alu8_bcd
    import bcd_alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e          op,
    input  logic [DW-1:0]    a_dst,
    input  logic [DW-1:0]    a_src,
    input  logic             cin,
    output logic [DW-1:0]    sum,
    output logic             cout
);
    localparam int NIB = DW / 4;

    logic [4:0] t;
    logic       k;     // decimal carry (add) or borrow (subtract) between digits

    // Digit by digit, low first; each digit is corrected by 6 when it leaves 0..9.
    always_comb begin
        sum = '0;
        t   = '0;
        if (op == OP_DSB) begin
            k = ~cin;
            for (int i = 0; i < NIB; i++) begin
                t = {1'b0, a_dst[i*4 +: 4]} - {1'b0, a_src[i*4 +: 4]} - {4'b0, k};
                if (t[4]) begin
                    sum[i*4 +: 4] = t[3:0] - 4'd6;
                    k = 1'b1;
                end else begin
                    sum[i*4 +: 4] = t[3:0];
                    k = 1'b0;
                end
            end
            cout = ~k;
        end else begin
            k = cin;
            for (int i = 0; i < NIB; i++) begin
                t = {1'b0, a_dst[i*4 +: 4]} + {1'b0, a_src[i*4 +: 4]} + {4'b0, k};
                if (t > 5'd9) begin
                    sum[i*4 +: 4] = t[3:0] + 4'd6;
                    k = 1'b1;
                end else begin
                    sum[i*4 +: 4] = t[3:0];
                    k = 1'b0;
                end
            end
            cout = k;
        end
    end
endmodule

// File: rtl/bcd_alu8_bits.sv
module bcd_alu8_bits
    import bcd_alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e          op,
    input  logic [DW-1:0]    a_dst,
    input  logic [DW-1:0]    a_src,
    input  logic             cin,
    output logic [DW-1:0]    r,
    output logic             cout
);
    localparam int HW = DW / 2;

    always_comb begin
        cout = 1'b0;
        case (op)
            OP_AND:  r = a_dst & a_src;
            OP_OR:   r = a_dst | a_src;
            OP_XOR:  r = a_dst ^ a_src;
            OP_INV:  r = ~a_dst;
            OP_CLR:  r = '0;
            OP_SWAP: r = {a_dst[HW-1:0], a_dst[DW-1:HW]};
            OP_TST:  r = a_dst;
            OP_RL: begin
                r    = {a_dst[DW-2:0], a_dst[DW-1]};
                cout = a_dst[DW-1];
            end
            OP_RLC: begin
                r    = {a_dst[DW-2:0], cin};
                cout = a_dst[DW-1];
            end
            OP_RR: begin
                r    = {a_dst[0], a_dst[DW-1:1]};
                cout = a_dst[0];
            end
            OP_RRC: begin
                r    = {cin, a_dst[DW-1:1]};
                cout = a_dst[0];
            end
            default: r = '0;
        endcase
    end
endmodule

// File: rtl/bcd_alu8.sv
module bcd_alu8
    import bcd_alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_en,
    input  logic [4:0]        op,
    input  logic [DW-1:0]     dst,
    input  logic [DW-1:0]     src,
    input  logic              cin,
    output logic [DW-1:0]     res,
    output logic              c_out,
    output logic              n_out,
    output logic              z_out,
    output logic [2*DW-1:0]   prod,
    output logic              flag_c,
    output logic              flag_n,
    output logic              flag_z
);
    localparam int PW  = 2 * DW;
    localparam int NIB = DW / 4;

    alu_op_e    opx;
    unit_sel_e  sel;
    logic [DW-1:0] as_sum, bcd_sum, lu_r, fv;
    logic       as_c, bcd_c, lu_c, op_ok;
    alu_flags_t now_f, flags_q;

    assign opx  = alu_op_e'(op);
    assign sel  = pick_unit(opx);
    assign prod = {{DW{1'b0}}, dst} * {{DW{1'b0}}, src};

    bcd_alu8_arith #(.DW(DW)) u_arith (
        .op(opx), .a_dst(dst), .a_src(src), .cin(cin), .sum(as_sum), .cout(as_c)
    );

    bcd_alu8_bcd #(.DW(DW)) u_bcd (
        .op(opx), .a_dst(dst), .a_src(src), .cin(cin), .sum(bcd_sum), .cout(bcd_c)
    );

    bcd_alu8_bits #(.DW(DW)) u_bits (
        .op(opx), .a_dst(dst), .a_src(src), .cin(cin), .r(lu_r), .cout(lu_c)
    );

    // fv is the value the sign and zero flags describe.
    always_comb begin
        res   = '0;
        fv    = '0;
        now_f = '0;
        op_ok = 1'b1;
        case (sel)
            SEL_ARITH: begin
                res     = (opx == OP_CMP) ? dst : as_sum;
                fv      = as_sum;
                now_f.c = as_c;
            end
            SEL_BCD: begin
                res     = bcd_sum;
                fv      = bcd_sum;
                now_f.c = bcd_c;
            end
            SEL_BITS: begin
                res     = lu_r;
                fv      = lu_r;
                now_f.c = lu_c;
            end
            SEL_MUL: begin
                res = prod[DW-1:0];
                fv  = prod[PW-1:DW];
            end
            default: op_ok = 1'b0;
        endcase
        now_f.n = op_ok & fv[DW-1];
        now_f.z = op_ok & (fv == '0);
    end

    assign c_out = now_f.c;
    assign n_out = now_f.n;
    assign z_out = now_f.z;

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else if (op_en && op_ok)
            flags_q <= now_f;
    end

    assign flag_c = flags_q.c;
    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;

    // Decimal digit legality of operands and result, used by the checks below.
    logic in_bcd, out_bcd;
    always_comb begin
        in_bcd  = 1'b1;
        out_bcd = 1'b1;
        for (int i = 0; i < NIB; i++) begin
            if (dst[i*4 +: 4] > 4'd9 || src[i*4 +: 4] > 4'd9) in_bcd = 1'b0;
            if (res[i*4 +: 4] > 4'd9) out_bcd = 1'b0;
        end
    end

    a_r13_hold: assert property (@(posedge clk) disable iff (rst)
        !op_en |=> $stable({flag_c, flag_n, flag_z}));

    a_r13_load: assert property (@(posedge clk) disable iff (rst)
        (op_en && op_ok) |=> (flag_c == $past(c_out)) && (flag_n == $past(n_out))
                             && (flag_z == $past(z_out)));

    a_r14_unused_hold: assert property (@(posedge clk) disable iff (rst)
        (op_en && op > 5'd20) |=> $stable({flag_c, flag_n, flag_z}));

    a_r6_carry_low: assert property (@(posedge clk) disable iff (rst)
        forces_c_low(opx) |-> !c_out);

    a_r3_cmp_keeps: assert property (@(posedge clk) disable iff (rst)
        (opx == OP_CMP) |-> (res == dst));

    a_r8_rl_wrap: assert property (@(posedge clk) disable iff (rst)
        (opx == OP_RL) |-> (res[0] == dst[DW-1]) && (c_out == dst[DW-1]));

    a_r4_digits_legal: assert property (@(posedge clk) disable iff (rst)
        ((opx == OP_DAC || opx == OP_DSB) && in_bcd) |-> out_bcd);

    a_r11_mpy_low: assert property (@(posedge clk) disable iff (rst)
        (opx == OP_MPY) |-> (res == prod[DW-1:0]) && (z_out == (prod[PW-1:DW] == '0)));
endmodule

// File: tb/bcd_alu8_tb.sv
`timescale 1ns/100ps
module bcd_alu8_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_en = 1'b0;
    logic [4:0]  op = 5'd0;
    logic [7:0]  dst = 8'd0, src = 8'd0;
    logic        cin = 1'b0;
    logic [7:0]  res;
    logic        c_out, n_out, z_out;
    logic [15:0] prod;
    logic        flag_c, flag_n, flag_z;

    int n_chk = 0;
    int n_bad = 0;

    bcd_alu8 u_dut (
        .clk(clk), .rst(rst), .op_en(op_en), .op(op), .dst(dst), .src(src), .cin(cin),
        .res(res), .c_out(c_out), .n_out(n_out), .z_out(z_out), .prod(prod),
        .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
    );

    always #2.5 clk = ~clk;

    function automatic string tag_of(int o);
        case (o)
            0, 1:   return "R1";
            2, 3:   return "R2";
            4:      return "R3";
            5:      return "R4";
            6:      return "R5";
            7, 8, 9, 10, 13: return "R6";
            11, 12: return "R7";
            15, 17: return "R8";
            16, 18: return "R9";
            14, 19: return "R10";
            20:     return "R11";
            default: return "R14";
        endcase
    endfunction

    function automatic int to_dec(logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] to_bcd(int v);
        logic [7:0] b;
        b[7:4] = 4'(v / 10);
        b[3:0] = 4'(v % 10);
        return b;
    endfunction

    // Reference model: {c, n, z, res}
    function automatic logic [10:0] model(int o, logic [7:0] d, logic [7:0] s, logic ci);
        int t;
        logic [7:0] r, fv;
        logic c;
        logic [15:0] p;
        c = 1'b0;
        r = 8'd0;
        t = 0;
        case (o)
            0: begin t = int'(d) + int'(s);        r = 8'(t); c = (t > 255); end
            1: begin t = int'(d) + int'(s) + int'(ci); r = 8'(t); c = (t > 255); end
            2, 4: begin t = int'(d) - int'(s);     r = 8'(t); c = (t >= 0); end
            3: begin t = int'(d) - int'(s) - 1 + int'(ci); r = 8'(t); c = (t >= 0); end
            5: begin
                t = to_dec(d) + to_dec(s) + int'(ci);
                c = (t >= 100);
                r = to_bcd(t % 100);
            end
            6: begin
                t = to_dec(d) - to_dec(s) - 1 + int'(ci);
                c = (t >= 0);
                if (t < 0) t = t + 100;
                r = to_bcd(t);
            end
            7:  r = d & s;
            8:  r = d | s;
            9:  r = d ^ s;
            10: r = ~d;
            11: begin t = int'(d) + 1; r = 8'(t); c = (t > 255); end
            12: begin r = d - 8'd1; c = (d != 8'd0); end
            13: r = 8'd0;
            14: r = {d[3:0], d[7:4]};
            15: begin r = {d[6:0], d[7]}; c = d[7]; end
            16: begin r = {d[6:0], ci};   c = d[7]; end
            17: begin r = {d[0], d[7:1]}; c = d[0]; end
            18: begin r = {ci, d[7:1]};   c = d[0]; end
            19: r = d;
            20: begin p = 16'(d) * 16'(s); r = p[7:0]; end
            default: r = 8'd0;
        endcase
        fv = r;
        if (o == 4) fv = 8'(t);
        if (o == 20) begin p = 16'(d) * 16'(s); fv = p[15:8]; end
        if (o > 20) return 11'd0;
        if (o == 4) r = d;
        return {c, fv[7], (fv == 8'd0), r};
    endfunction

    task automatic check_vec(int o, logic [7:0] d, logic [7:0] s, logic ci);
        logic [10:0] e;
        op = 5'(o); dst = d; src = s; cin = ci;
        #0.1;
        e = model(o, d, s, ci);
        n_chk++;
        if ({c_out, n_out, z_out, res} !== e || prod !== 16'(d) * 16'(s)) begin
            n_bad++;
            $display("FAIL %s op=%0d d=%h s=%h ci=%0d: got c%0d n%0d z%0d r=%h p=%h exp c%0d n%0d z%0d r=%h p=%h",
                     tag_of(o), o, d, s, ci, c_out, n_out, z_out, res, prod,
                     e[10], e[9], e[8], e[7:0], 16'(d) * 16'(s));
        end
    endtask

    task automatic check_flags(string tg, logic ec, logic en, logic ez);
        n_chk++;
        if ({flag_c, flag_n, flag_z} !== {ec, en, ez}) begin
            n_bad++;
            $display("FAIL %s flags got c%0d n%0d z%0d exp c%0d n%0d z%0d",
                     tg, flag_c, flag_n, flag_z, ec, en, ez);
        end
    endtask

    task automatic issue(int o, logic [7:0] d, logic [7:0] s, logic ci, logic en);
        @(negedge clk);
        op = 5'(o); dst = d; src = s; cin = ci; op_en = en;
        @(negedge clk);
        op_en = 1'b0;
    endtask

    initial begin : watchdog
        #1000000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_flags("R13", 1'b0, 1'b0, 1'b0);   // reset state
        rst = 1'b0;
        @(negedge clk);

        // Binary and bitwise ops: every dst against a spread of src values (R1-R3, R6-R12)
        for (int o = 0; o <= 20; o++) begin
            if (o == 5 || o == 6) continue;
            for (int d = 0; d < 256; d++)
                for (int s = 0; s < 256; s += 5)
                    for (int ci = 0; ci < 2; ci++)
                        check_vec(o, 8'(d), 8'(s), 1'(ci));
            check_vec(o, 8'hFF, 8'hFF, 1'b1);
        end

        // Decimal ops: all valid digit pairs, both carries (R4, R5)
        for (int o = 5; o <= 6; o++)
            for (int a = 0; a < 100; a++)
                for (int b = 0; b < 100; b++)
                    for (int ci = 0; ci < 2; ci++)
                        check_vec(o, to_bcd(a), to_bcd(b), 1'(ci));

        // Unused codes (R14)
        for (int o = 21; o < 32; o++)
            check_vec(o, 8'hA5, 8'h3C, 1'b1);

        // Flag register sequence (R13, R14, R11)
        @(negedge clk);
        issue(0, 8'hFF, 8'h01, 1'b0, 1'b1);        // sum 0x100: c1 n0 z1
        check_flags("R13", 1'b1, 1'b0, 1'b1);
        issue(7, 8'h80, 8'h80, 1'b0, 1'b0);        // not issued: hold
        check_flags("R13", 1'b1, 1'b0, 1'b1);
        issue(25, 8'h00, 8'h00, 1'b0, 1'b1);       // unused code: hold
        check_flags("R14", 1'b1, 1'b0, 1'b1);
        issue(20, 8'h10, 8'h10, 1'b0, 1'b1);       // 0x0100: low byte zero, high not
        check_flags("R11", 1'b0, 1'b0, 1'b0);
        issue(20, 8'hFF, 8'hFF, 1'b0, 1'b1);       // 0xFE01: n from high byte
        check_flags("R11", 1'b0, 1'b1, 1'b0);
        issue(6, 8'h00, 8'h00, 1'b0, 1'b1);        // 00-00-1 -> 99, borrow
        check_flags("R5", 1'b0, 1'b1, 1'b0);
        issue(12, 8'h00, 8'h00, 1'b0, 1'b1);       // dec 00 -> FF, c0
        check_flags("R7", 1'b0, 1'b1, 1'b0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule